// File: doc/BRIEF.md
# Camera Packet Header Decoder

This block decodes the 32-bit header that opens each packet on a camera serial link. The word holds an identifier byte (virtual channel and data type), a 16-bit field that is either a payload length or short-packet data, and an error-check byte. The block uses the check byte to repair any single flipped bit and to detect any two flipped bits. It then splits the repaired header into its fields, tells short packets from long ones, and marks embedded non-image packets so that a downstream stage can steer them to their own output.

A header is presented with a one-cycle valid strobe. All outputs are registered, so the decoded result appears one clock later. A mode input that is sampled with the header widens the channel number from 2 to 4 bits. The two extra bits come from the otherwise unused top of the check byte. Payload and CRC handling belong to later stages.

Top module: `cam_hdr_decoder`

## Requirements
- R1: After reset, every output is 0.
- R2: Word layout: bits 5:0 are the data type, bits 7:6 are the low channel bits, bits 23:8 are the 16-bit field, bits 29:24 are the 6-bit check code, and bits 31:30 are the extension bits. For an error-free header with hdr_valid high in cycle k, pkt_start is high for exactly cycle k+1, and dtype, vc and word_cnt show the header fields.
- R3: A header with exactly one flipped bit among bits 23:0 is repaired. Its fields come out as in the original, pkt_start pulses, and corr_pulse is high for that one cycle.
- R4: A header with exactly one flipped bit among check bits 29:24 gives the original fields, pkt_start and a one-cycle corr_pulse.
- R5: A header with two flipped bits among bits 29:0 gives no pkt_start and no corr_pulse. The fields keep their previous values. hdr_err goes high and stays high until reset.
- R6: Data types 0x00 to 0x0F set is_short. All other types set is_long. Every 16-bit field value, including 0x0000 and 0xFFFF, is passed through unchanged.
- R7: Data type 0x12 sets is_embedded together with is_long. No other type sets is_embedded.
- R8: With ext_vc_en high when the header is sampled, vc is {bits 31:30, bits 7:6}.
- R9: With ext_vc_en low, vc[3:2] is 0 whatever bits 31:30 hold. Bits 31:30 never affect error checking.
- R10: route_tag is {dtype, vc}: data type in bits 9:4 and channel in bits 3:0.
- R11: A cycle without hdr_valid gives no pkt_start and no corr_pulse, and leaves every field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header word present this cycle |
| hdr_word | input | 32 | Packet header word |
| ext_vc_en | input | 1 | Widen the virtual channel to 4 bits |
| pkt_start | output | 1 | One-cycle pulse for an accepted header |
| vc | output | 4 | Virtual channel |
| dtype | output | 6 | Data type |
| word_cnt | output | 16 | Payload length or short-packet data |
| is_short | output | 1 | Short-packet class |
| is_long | output | 1 | Long-packet class |
| is_embedded | output | 1 | Embedded non-image class |
| route_tag | output | 10 | {data type, channel} routing tag |
| corr_pulse | output | 1 | One-cycle pulse when a bit was repaired |
| hdr_err | output | 1 | Sticky flag for an uncorrectable header |

## Verification
The assertions assume that hdr_valid is never high with an X header and that at most two bits of any header are corrupted. Three or more flipped bits can look like a repairable single error, and no property separates that case. The stimulus builds every header from a clean word whose check code is computed in the bench, then flips zero, one or two chosen bit positions. It drives at the falling edge so that each header is seen by exactly one rising edge.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;
   localparam int DATA_W  = 24;
   localparam int CODE_W  = 6;
   localparam int DT_W    = 6;
   localparam int VC_W    = 4;
   localparam int FIELD_W = 16;
   localparam int TAG_W   = DT_W + VC_W;

   // syndrome column for each protected header bit (weight 3 or 5)
   function automatic logic [CODE_W-1:0] code_col(input int idx);
      logic [CODE_W-1:0] c;
      case (idx)
         0: c = 6'h07;  1: c = 6'h0B;  2: c = 6'h0D;  3: c = 6'h0E;
         4: c = 6'h13;  5: c = 6'h15;  6: c = 6'h16;  7: c = 6'h19;
         8: c = 6'h1A;  9: c = 6'h1C; 10: c = 6'h23; 11: c = 6'h25;
        12: c = 6'h26; 13: c = 6'h29; 14: c = 6'h2A; 15: c = 6'h2C;
        16: c = 6'h31; 17: c = 6'h32; 18: c = 6'h34; 19: c = 6'h38;
        20: c = 6'h1F; 21: c = 6'h2F; 22: c = 6'h37; 23: c = 6'h3B;
        default: c = '0;
      endcase
      return c;
   endfunction

   typedef struct packed {
      logic [VC_W-1:0]    vc;
      logic [DT_W-1:0]    dt;
      logic [FIELD_W-1:0] wc;
      logic               short_pkt;
      logic               embed_pkt;
   } hdr_fields_t;
endpackage

// File: rtl/hdr_secded.sv
module hdr_secded
   import hdr_ecc_pkg::*;
(
   input  logic [DATA_W-1:0] data_in,
   input  logic [CODE_W-1:0] code_in,
   output logic [DATA_W-1:0] data_fix,
   output logic              fixed,
   output logic              bad
);
   logic [CODE_W-1:0] calc;
   logic [CODE_W-1:0] synd;
   logic [DATA_W-1:0] flip;
   logic              code_bit_err;

   always_comb begin
      calc = '0;
      for (int i = 0; i < DATA_W; i++)
         if (data_in[i]) calc = calc ^ code_col(i);
   end

   assign synd = calc ^ code_in;

   genvar g;
   generate
      for (g = 0; g < DATA_W; g++) begin : g_flip
         assign flip[g] = (synd == code_col(g));
      end
   endgenerate

   assign code_bit_err = ($countones(synd) == 1);
   assign data_fix     = data_in ^ flip;
   assign fixed        = (|flip) | code_bit_err;
   assign bad          = (synd != '0) & ~fixed;
endmodule

// File: rtl/hdr_field_split.sv
module hdr_field_split
   import hdr_ecc_pkg::*;
#(
   parameter logic [DT_W-1:0] SHORT_MAX = 6'h0F,
   parameter logic [DT_W-1:0] DT_EMBED  = 6'h12,
   parameter bit              EXT_VC_EN = 1'b1
)(
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        ext_bits,
   input  logic              ext_mode,
   output hdr_fields_t       fields
);
   logic [1:0] vc_hi;

   generate
      if (EXT_VC_EN) begin : g_ext
         assign vc_hi = ext_mode ? ext_bits : 2'b00;
      end else begin : g_noext
         assign vc_hi = 2'b00;
      end
   endgenerate

   always_comb begin
      fields.dt        = data[DT_W-1:0];
      fields.vc        = {vc_hi, data[7:6]};
      fields.wc        = data[8 +: FIELD_W];
      fields.short_pkt = (data[DT_W-1:0] <= SHORT_MAX);
      fields.embed_pkt = (data[DT_W-1:0] == DT_EMBED);
   end
endmodule

// File: rtl/cam_hdr_decoder.sv
module cam_hdr_decoder
   import hdr_ecc_pkg::*;
#(
   parameter logic [DT_W-1:0] SHORT_MAX = 6'h0F,
   parameter logic [DT_W-1:0] DT_EMBED  = 6'h12,
   parameter bit              EXT_VC_EN = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hdr_valid,
   input  logic [31:0] hdr_word,
   input  logic        ext_vc_en,
   output logic        pkt_start,
   output logic [3:0]  vc,
   output logic [5:0]  dtype,
   output logic [15:0] word_cnt,
   output logic        is_short,
   output logic        is_long,
   output logic        is_embedded,
   output logic [9:0]  route_tag,
   output logic        corr_pulse,
   output logic        hdr_err
);
   generate
      if (DT_EMBED <= SHORT_MAX) begin : g_bad_cfg
         $error("embedded data type must be a long-packet type");
      end
      if (DATA_W + CODE_W + 2 != 32) begin : g_bad_w
         $error("header layout must fill 32 bits");
      end
   endgenerate

   logic [DATA_W-1:0] data_fix;
   logic              fixed, bad;
   hdr_fields_t       f_next, f_q;
   logic              start_q, corr_q, err_q, mode_q;

   hdr_secded u_secded (
      .data_in  (hdr_word[DATA_W-1:0]),
      .code_in  (hdr_word[DATA_W +: CODE_W]),
      .data_fix (data_fix),
      .fixed    (fixed),
      .bad      (bad)
   );

   hdr_field_split #(
      .SHORT_MAX (SHORT_MAX),
      .DT_EMBED  (DT_EMBED),
      .EXT_VC_EN (EXT_VC_EN)
   ) u_split (
      .data     (data_fix),
      .ext_bits (hdr_word[31:30]),
      .ext_mode (ext_vc_en),
      .fields   (f_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q     <= '0;
         start_q <= 1'b0;
         corr_q  <= 1'b0;
         err_q   <= 1'b0;
         mode_q  <= 1'b0;
      end else begin
         start_q <= hdr_valid & ~bad;
         corr_q  <= hdr_valid & fixed;
         if (hdr_valid & bad) err_q <= 1'b1;
         if (hdr_valid & ~bad) begin
            f_q    <= f_next;
            mode_q <= ext_vc_en & EXT_VC_EN;
         end
      end
   end

   logic any_q;
   assign any_q = start_q;

   assign pkt_start   = start_q;
   assign vc          = f_q.vc;
   assign dtype       = f_q.dt;
   assign word_cnt    = f_q.wc;
   assign is_short    = f_q.short_pkt;
   assign is_long     = ~f_q.short_pkt & (f_q.dt != '0 | f_q.vc != '0 | f_q.wc != '0 | any_q);
   assign is_embedded = f_q.embed_pkt;
   assign route_tag   = {f_q.dt, f_q.vc};
   assign corr_pulse  = corr_q;
   assign hdr_err     = err_q;

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_err |=> hdr_err);
   // R3
   corr_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      corr_pulse |-> pkt_start);
   // R5
   bad_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && bad) |=> (!pkt_start && !corr_pulse && hdr_err));
   // R6
   class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> (is_short ^ is_long));
   // R7
   embed_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_embedded |-> is_long);
   // R9
   vc_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && !mode_q) |-> (vc[3:2] == 2'b00));
   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> (!pkt_start && $stable(route_tag) && $stable(word_cnt)));
endmodule

// File: tb/cam_hdr_decoder_tb.sv
module cam_hdr_decoder_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        hdr_valid = 0;
   logic [31:0] hdr_word = '0;
   logic        ext_vc_en = 0;
   logic        pkt_start, corr_pulse, hdr_err, is_short, is_long, is_embedded;
   logic [3:0]  vc;
   logic [5:0]  dtype;
   logic [15:0] word_cnt;
   logic [9:0]  route_tag;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cam_hdr_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
      .ext_vc_en(ext_vc_en), .pkt_start(pkt_start), .vc(vc), .dtype(dtype),
      .word_cnt(word_cnt), .is_short(is_short), .is_long(is_long),
      .is_embedded(is_embedded), .route_tag(route_tag),
      .corr_pulse(corr_pulse), .hdr_err(hdr_err)
   );

   function automatic logic [5:0] calc_ecc(input logic [23:0] d);
      return {^(d & 24'hEFFC00), ^(d & 24'hDF03F0), ^(d & 24'hB8E38E),
              ^(d & 24'h749A6D), ^(d & 24'hF2555B), ^(d & 24'hF12CB7)};
   endfunction

   function automatic logic [31:0] mk(input logic [1:0] ext, input logic [1:0] vlo,
                                      input logic [5:0] dt, input logic [15:0] wc);
      logic [23:0] d;
      d = {wc, vlo, dt};
      return {ext, calc_ecc(d), d};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at falling edge; registered result is visible at the next falling edge
   task automatic send(input logic [31:0] w, input logic mode);
      @(negedge clk);
      hdr_valid = 1; hdr_word = w; ext_vc_en = mode;
      @(negedge clk);
      hdr_valid = 0; hdr_word = '0; ext_vc_en = 0;
   endtask

   task automatic expect_hdr(input string req, input logic [3:0] evc, input logic [5:0] edt,
                             input logic [15:0] ewc, input logic ecorr);
      chk({req, " start"}, pkt_start, 1);
      chk({req, " vc"}, vc, evc);
      chk({req, " dtype"}, dtype, edt);
      chk({req, " wc"}, word_cnt, ewc);
      chk({req, " corr"}, corr_pulse, ecorr);
      chk({req, " tag R10"}, route_tag, {edt, evc});
   endtask

   task automatic t_reset();
      chk("R1 outputs", {pkt_start, vc, dtype, word_cnt, is_short, is_long,
                         is_embedded, route_tag, corr_pulse, hdr_err}, '0);
   endtask

   task automatic t_clean();
      send(mk(2'b00, 2'b10, 6'h2B, 16'h0500), 0);
      expect_hdr("R2 clean", 4'h2, 6'h2B, 16'h0500, 0);
      chk("R6 long", {is_short, is_long, is_embedded}, 3'b010);
      @(negedge clk);
      chk("R2 one-cycle start", pkt_start, 0);
   endtask

   task automatic t_short();
      send(mk(2'b00, 2'b01, 6'h00, 16'h0000), 0);
      expect_hdr("R6 short fs", 4'h1, 6'h00, 16'h0000, 0);
      chk("R6 short class", {is_short, is_long}, 2'b10);
      send(mk(2'b00, 2'b11, 6'h0F, 16'hFFFF), 0);
      expect_hdr("R6 short edge", 4'h3, 6'h0F, 16'hFFFF, 0);
      chk("R6 short 0x0F", {is_short, is_long}, 2'b10);
      send(mk(2'b00, 2'b00, 6'h10, 16'hFFFF), 0);
      chk("R6 long 0x10", {is_short, is_long, is_embedded}, 3'b010);
      chk("R6 wc max", word_cnt, 16'hFFFF);
   endtask

   task automatic t_embed();
      send(mk(2'b00, 2'b01, 6'h12, 16'h0040), 0);
      expect_hdr("R7 embed", 4'h1, 6'h12, 16'h0040, 0);
      chk("R7 embed class", {is_short, is_long, is_embedded}, 3'b011);
      send(mk(2'b00, 2'b01, 6'h13, 16'h0040), 0);
      chk("R7 not embed", is_embedded, 0);
   endtask

   task automatic t_single();
      for (int b = 0; b < 24; b += 5) begin
         send(mk(2'b00, 2'b10, 6'h24, 16'hA5C3) ^ (32'h1 << b), 0);
         expect_hdr("R3 data bit", 4'h2, 6'h24, 16'hA5C3, 1);
      end
      for (int b = 24; b < 30; b++) begin
         send(mk(2'b00, 2'b01, 6'h2A, 16'h1234) ^ (32'h1 << b), 0);
         expect_hdr("R4 code bit", 4'h1, 6'h2A, 16'h1234, 1);
      end
      @(negedge clk);
      chk("R3 corr one cycle", corr_pulse, 0);
   endtask

   task automatic t_ext();
      send(mk(2'b11, 2'b01, 6'h2B, 16'h0780), 1);
      expect_hdr("R8 ext on", 4'hD, 6'h2B, 16'h0780, 0);
      send(mk(2'b10, 2'b00, 6'h1E, 16'h0100) ^ 32'h0000_0200, 1);
      expect_hdr("R8 ext fixed", 4'h8, 6'h1E, 16'h0100, 1);
      send(mk(2'b11, 2'b10, 6'h2B, 16'h0780), 0);
      expect_hdr("R9 ext off", 4'h2, 6'h2B, 16'h0780, 0);
   endtask

   task automatic t_idle();
      repeat (3) @(negedge clk);
      chk("R11 no start", pkt_start, 0);
      chk("R11 no corr", corr_pulse, 0);
      chk("R11 tag held", route_tag, {6'h2B, 4'h2});
      chk("R11 wc held", word_cnt, 16'h0780);
   endtask

   task automatic t_double();
      chk("R5 err clear", hdr_err, 0);
      send(mk(2'b00, 2'b11, 6'h22, 16'h4444) ^ 32'h0000_0101, 0);
      chk("R5 no start", pkt_start, 0);
      chk("R5 no corr", corr_pulse, 0);
      chk("R5 err set", hdr_err, 1);
      chk("R5 fields held", {route_tag, word_cnt}, {6'h2B, 4'h2, 16'h0780});
      send(mk(2'b00, 2'b00, 6'h2C, 16'h0010) ^ 32'h2000_0001, 0);
      chk("R5 data+code no start", pkt_start, 0);
      send(mk(2'b00, 2'b01, 6'h2C, 16'h0020), 0);
      expect_hdr("R5 after err", 4'h1, 6'h2C, 16'h0020, 0);
      chk("R5 err sticky", hdr_err, 1);
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      chk("R5 err cleared by reset", hdr_err, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_short();
      t_embed();
      t_single();
      t_ext();
      t_idle();
      t_double();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule